// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a host on a small memory-mapped register bus access to two internal register files that are not directly mapped. Each file is reached through its own channel of three host registers: a pointer register that selects an internal location, a data window through which that location is read or written, and a control register. Channel A fronts a file of 32-bit registers. Channel B fronts a file of 8-bit registers with a 16-bit address space.

A pointer only takes effect after the host writes the same value to it twice in a row. A read through the data window takes two host reads. The first starts the internal fetch and returns whatever was fetched last. The second returns the freshly fetched word. A write through the window takes one host access and goes straight to the internal file. Accesses that break these rules are suppressed. They can be reported as error responses when the channel's control register asks for that.

The host holds a request until the bridge acknowledges it. While an internal fetch is in flight, the bridge holds off new requests, so the second window read always sees the fetched value. Each internal file is driven through a synchronous port: an enable, a write strobe, an address and write data, with read data arriving one cycle after an enabled read.

Top module: `ibr_bridge`

## Requirements
- R1: Host offset decode: bit 4 selects the channel (0 = A, 1 = B) and bits [3:2] select the register (0 pointer, 1 data window, 2 control). Bits [1:0] and every bit above bit 4 must be zero. Any other offset, including register field 3, acknowledges with read data 0 and no error, and changes no state.
- R2: A request is accepted on a clock edge where host_req is high, no acknowledge is pending and no internal fetch is in flight. host_ack pulses for one cycle after acceptance, carrying host_rdata and host_err. A write acknowledge carries read data 0. After an internal read is issued, the bridge acknowledges nothing in the cycle that follows.
- R3: Only bits [15:0] of a pointer write are used. An internal address is committed when two consecutive pointer writes on a channel carry equal low halves. The first write of a pair withdraws any previous commit. After a mismatched pair, the later value begins a new pair. Reading the pointer register returns the last written low half, zero-extended.
- R4: With a committed address, the first data-window read issues an internal read and returns the previously fetched value (0 after reset). The next data-window read returns the value fetched from the committed address. Any pointer or data-window write resets this two-read sequence.
- R5: With a committed address, one data-window write issues one internal write of the host data to the committed address. On channel B, only bits [7:0] are written.
- R6: A data-window access with no committed address, and the second write of a mismatched pointer pair, are sequence violations. A violating data-window access issues no internal access, and a violating read returns 0.
- R7: Bit 15 of a channel's control register enables error reporting. A violation on that channel then acknowledges with host_err high. With the bit clear, violations acknowledge without error. Reading the control register returns bit 15 in place and 0 in every other bit.
- R8: The two channels keep separate state. An access on one channel never changes the pointer, commit, read sequence, fetched value or control bit of the other.
- R9: Channel B reads return the 8-bit register value zero-extended to 32 bits.
- R10: After reset, no address is committed on either channel, error reporting is off, the fetched values are 0, and host_ack, host_err and both internal enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host request, held until acknowledged |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | HOST_AW (8) | Host byte offset |
| host_wdata | input | BUS_W (32) | Host write data |
| host_ack | output | 1 | One-cycle acknowledge |
| host_err | output | 1 | Error response, valid with host_ack |
| host_rdata | output | BUS_W (32) | Read data, valid with host_ack |
| main_rf_en | output | 1 | Channel A internal access enable |
| main_rf_we | output | 1 | Channel A internal write strobe |
| main_rf_addr | output | ADDR_W (16) | Channel A internal address |
| main_rf_wdata | output | MAIN_DW (32) | Channel A internal write data |
| main_rf_rdata | input | MAIN_DW (32) | Channel A read data, one cycle after a read enable |
| ctl_rf_en | output | 1 | Channel B internal access enable |
| ctl_rf_we | output | 1 | Channel B internal write strobe |
| ctl_rf_addr | output | ADDR_W (16) | Channel B internal address |
| ctl_rf_wdata | output | CTL_DW (8) | Channel B internal write data |
| ctl_rf_rdata | input | CTL_DW (8) | Channel B read data, one cycle after a read enable |

## Verification
The hardest states to reach from the ports are the ones where the two channels are in different phases at once. One example is a half-written pointer pair on one channel while the other channel sits between the two reads of a fetch. Another is a mismatched pair followed by a repeat that must commit the later value. Random stimulus reaches these by choosing the channel independently for each access and by repeating the channel's last pointer value most of the time. Pointer values are also drawn from a small pool, so both matching pairs and near-miss pairs occur often. Directed sequences add the cases after reset, error reporting on and off, and the B-channel truncation and zero extension.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic     hit;
    logic     chan;
    reg_sel_e sel;
  } host_dec_t;

  localparam int ERR_EN_BIT = 15;

endpackage

// File: rtl/ibr_decode.sv
module ibr_decode
  import ibr_pkg::*;
#(
  parameter int HOST_AW = 8
) (
  input  logic [HOST_AW-1:0] host_addr,
  output host_dec_t          dec
);

  localparam int CHAN_BIT = 4;

  logic upper_zero;

  generate
    if (HOST_AW > CHAN_BIT + 1) begin : g_upper
      assign upper_zero = (host_addr[HOST_AW-1:CHAN_BIT+1] == '0);
    end else begin : g_noupper
      assign upper_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    dec.chan = host_addr[CHAN_BIT];
    dec.sel  = reg_sel_e'(host_addr[3:2]);
    dec.hit  = upper_zero && (host_addr[1:0] == 2'b00) && (host_addr[3:2] != 2'd3);
  end

endmodule

// File: rtl/ibr_channel.sv
module ibr_channel
  import ibr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic              acc_we,
  input  reg_sel_e          acc_sel,
  input  logic [BUS_W-1:0]  acc_wdata,
  output logic [BUS_W-1:0]  rsp_rdata,
  output logic              rsp_viol,
  output logic              err_en,
  output logic              busy,
  output logic              rf_en,
  output logic              rf_we,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_wdata,
  input  logic [DATA_W-1:0] rf_rdata
);

  logic [ADDR_W-1:0] pend_addr;
  logic              pend_valid;
  logic [ADDR_W-1:0] commit_addr;
  logic              commit_valid;
  logic              rd_phase;
  logic              fetch_wait;
  logic [DATA_W-1:0] fetched;

  logic [BUS_W-1:0]  fetched_ext;
  logic [BUS_W-1:0]  pend_ext;
  logic [ADDR_W-1:0] wr_ptr;
  logic              ptr_match;
  logic              issue_rd;
  logic              issue_wr;
  logic              unused_bits;

  assign wr_ptr      = acc_wdata[ADDR_W-1:0];
  assign ptr_match   = (pend_addr == wr_ptr);
  assign unused_bits = ^acc_wdata;

  generate
    if (DATA_W == BUS_W) begin : g_full
      assign fetched_ext = fetched;
    end else begin : g_narrow
      assign fetched_ext = {{(BUS_W-DATA_W){1'b0}}, fetched};
    end
    if (ADDR_W == BUS_W) begin : g_pfull
      assign pend_ext = pend_addr;
    end else begin : g_pnarrow
      assign pend_ext = {{(BUS_W-ADDR_W){1'b0}}, pend_addr};
    end
  endgenerate

  always_comb begin
    rsp_rdata = '0;
    rsp_viol  = 1'b0;
    issue_rd  = 1'b0;
    issue_wr  = 1'b0;
    if (acc) begin
      unique case (acc_sel)
        SEL_PTR: begin
          if (acc_we) rsp_viol = pend_valid && !ptr_match;
          else        rsp_rdata = pend_ext;
        end
        SEL_DATA: begin
          rsp_viol = !commit_valid;
          if (commit_valid) begin
            if (acc_we) begin
              issue_wr = 1'b1;
            end else begin
              rsp_rdata = fetched_ext;
              issue_rd  = !rd_phase;
            end
          end
        end
        SEL_CTRL: begin
          if (!acc_we) rsp_rdata[ERR_EN_BIT] = err_en;
        end
        default: ;
      endcase
    end
  end

  assign busy = rf_en | fetch_wait;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_addr    <= '0;
      pend_valid   <= 1'b0;
      commit_addr  <= '0;
      commit_valid <= 1'b0;
      rd_phase     <= 1'b0;
      fetch_wait   <= 1'b0;
      fetched      <= '0;
      err_en       <= 1'b0;
      rf_en        <= 1'b0;
      rf_we        <= 1'b0;
      rf_addr      <= '0;
      rf_wdata     <= '0;
    end else begin
      rf_en      <= issue_rd | issue_wr;
      rf_we      <= issue_wr;
      fetch_wait <= rf_en && !rf_we;
      if (issue_rd | issue_wr) begin
        rf_addr  <= commit_addr;
        rf_wdata <= acc_wdata[DATA_W-1:0];
      end
      if (fetch_wait) fetched <= rf_rdata;

      if (acc) begin
        unique case (acc_sel)
          SEL_PTR: begin
            if (acc_we) begin
              rd_phase <= 1'b0;
              if (pend_valid && ptr_match) begin
                commit_addr  <= wr_ptr;
                commit_valid <= 1'b1;
                pend_valid   <= 1'b0;
              end else begin
                pend_valid   <= 1'b1;
                commit_valid <= 1'b0;
              end
              pend_addr <= wr_ptr;
            end
          end
          SEL_DATA: begin
            if (commit_valid) begin
              if (acc_we) rd_phase <= 1'b0;
              else        rd_phase <= !rd_phase;
            end
          end
          SEL_CTRL: begin
            if (acc_we) err_en <= acc_wdata[ERR_EN_BIT];
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge
  import ibr_pkg::*;
#(
  parameter int HOST_AW = 8,
  parameter int BUS_W   = 32,
  parameter int ADDR_W  = 16,
  parameter int MAIN_DW = 32,
  parameter int CTL_DW  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [BUS_W-1:0]   host_wdata,
  output logic               host_ack,
  output logic               host_err,
  output logic [BUS_W-1:0]   host_rdata,
  output logic               main_rf_en,
  output logic               main_rf_we,
  output logic [ADDR_W-1:0]  main_rf_addr,
  output logic [MAIN_DW-1:0] main_rf_wdata,
  input  logic [MAIN_DW-1:0] main_rf_rdata,
  output logic               ctl_rf_en,
  output logic               ctl_rf_we,
  output logic [ADDR_W-1:0]  ctl_rf_addr,
  output logic [CTL_DW-1:0]  ctl_rf_wdata,
  input  logic [CTL_DW-1:0]  ctl_rf_rdata
);

  host_dec_t        dec;
  logic             accept;
  logic             acc_main;
  logic             acc_ctl;
  logic [BUS_W-1:0] main_rdata;
  logic [BUS_W-1:0] ctl_rdata;
  logic             main_viol;
  logic             ctl_viol;
  logic             main_err_en;
  logic             ctl_err_en;
  logic             main_busy;
  logic             ctl_busy;
  logic [BUS_W-1:0] sel_rdata;
  logic             sel_err;

  ibr_decode #(.HOST_AW(HOST_AW)) u_dec (
    .host_addr (host_addr),
    .dec       (dec)
  );

  assign accept   = host_req && !host_ack && !main_busy && !ctl_busy;
  assign acc_main = accept && dec.hit && !dec.chan;
  assign acc_ctl  = accept && dec.hit &&  dec.chan;

  ibr_channel #(.ADDR_W(ADDR_W), .DATA_W(MAIN_DW), .BUS_W(BUS_W)) u_main (
    .clk       (clk),
    .rst       (rst),
    .acc       (acc_main),
    .acc_we    (host_we),
    .acc_sel   (dec.sel),
    .acc_wdata (host_wdata),
    .rsp_rdata (main_rdata),
    .rsp_viol  (main_viol),
    .err_en    (main_err_en),
    .busy      (main_busy),
    .rf_en     (main_rf_en),
    .rf_we     (main_rf_we),
    .rf_addr   (main_rf_addr),
    .rf_wdata  (main_rf_wdata),
    .rf_rdata  (main_rf_rdata)
  );

  ibr_channel #(.ADDR_W(ADDR_W), .DATA_W(CTL_DW), .BUS_W(BUS_W)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .acc       (acc_ctl),
    .acc_we    (host_we),
    .acc_sel   (dec.sel),
    .acc_wdata (host_wdata),
    .rsp_rdata (ctl_rdata),
    .rsp_viol  (ctl_viol),
    .err_en    (ctl_err_en),
    .busy      (ctl_busy),
    .rf_en     (ctl_rf_en),
    .rf_we     (ctl_rf_we),
    .rf_addr   (ctl_rf_addr),
    .rf_wdata  (ctl_rf_wdata),
    .rf_rdata  (ctl_rf_rdata)
  );

  always_comb begin
    sel_rdata = '0;
    sel_err   = 1'b0;
    if (dec.hit) begin
      if (dec.chan) begin
        sel_rdata = ctl_rdata;
        sel_err   = ctl_viol && ctl_err_en;
      end else begin
        sel_rdata = main_rdata;
        sel_err   = main_viol && main_err_en;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_ack   <= 1'b0;
      host_err   <= 1'b0;
      host_rdata <= '0;
    end else begin
      host_ack   <= accept;
      host_err   <= accept && sel_err;
      host_rdata <= accept ? sel_rdata : '0;
    end
  end

endmodule

// File: rtl/ibr_bridge_chk.sv
module ibr_bridge_chk #(
  parameter int HOST_AW = 8,
  parameter int BUS_W   = 32,
  parameter int ADDR_W  = 16,
  parameter int MAIN_DW = 32,
  parameter int CTL_DW  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               host_req,
  input logic               host_we,
  input logic [HOST_AW-1:0] host_addr,
  input logic [BUS_W-1:0]   host_wdata,
  input logic               host_ack,
  input logic               host_err,
  input logic [BUS_W-1:0]   host_rdata,
  input logic               main_rf_en,
  input logic               main_rf_we,
  input logic [ADDR_W-1:0]  main_rf_addr,
  input logic [MAIN_DW-1:0] main_rf_wdata,
  input logic [MAIN_DW-1:0] main_rf_rdata,
  input logic               ctl_rf_en,
  input logic               ctl_rf_we,
  input logic [ADDR_W-1:0]  ctl_rf_addr,
  input logic [CTL_DW-1:0]  ctl_rf_wdata,
  input logic [CTL_DW-1:0]  ctl_rf_rdata
);

  a_r2_ack_after_req: assert property (@(posedge clk) disable iff (rst)
    host_ack |-> $past(host_req));

  a_r2_write_ack_zero: assert property (@(posedge clk) disable iff (rst)
    (host_ack && $past(host_we)) |-> (host_rdata == '0));

  a_r2_hold_after_fetch: assert property (@(posedge clk) disable iff (rst)
    (main_rf_en && !main_rf_we) |=> !host_ack);

  a_r7_err_only_with_ack: assert property (@(posedge clk) disable iff (rst)
    host_err |-> host_ack);

  a_r5_main_write_from_host: assert property (@(posedge clk) disable iff (rst)
    (main_rf_en && main_rf_we) |-> $past(host_req && host_we));

  a_r5_ctl_write_low_byte: assert property (@(posedge clk) disable iff (rst)
    (ctl_rf_en && ctl_rf_we) |-> (ctl_rf_wdata == $past(host_wdata[CTL_DW-1:0])));

  a_r4_read_from_host: assert property (@(posedge clk) disable iff (rst)
    (main_rf_en && !main_rf_we) |-> $past(host_req && !host_we));

  a_r8_one_channel: assert property (@(posedge clk) disable iff (rst)
    !(main_rf_en && ctl_rf_en));

endmodule

bind ibr_bridge ibr_bridge_chk #(
  .HOST_AW (HOST_AW),
  .BUS_W   (BUS_W),
  .ADDR_W  (ADDR_W),
  .MAIN_DW (MAIN_DW),
  .CTL_DW  (CTL_DW)
) u_chk (.*);

// File: tb/ibr_bridge_test.sv
module ibr_bridge_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        host_ack;
  logic        host_err;
  logic [31:0] host_rdata;
  logic        main_rf_en, main_rf_we;
  logic [15:0] main_rf_addr;
  logic [31:0] main_rf_wdata;
  logic [31:0] main_rf_rdata = '0;
  logic        ctl_rf_en, ctl_rf_we;
  logic [15:0] ctl_rf_addr;
  logic [7:0]  ctl_rf_wdata;
  logic [7:0]  ctl_rf_rdata = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ibr_bridge uut (
    .clk(clk), .rst(rst),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_ack(host_ack), .host_err(host_err),
    .host_rdata(host_rdata),
    .main_rf_en(main_rf_en), .main_rf_we(main_rf_we), .main_rf_addr(main_rf_addr),
    .main_rf_wdata(main_rf_wdata), .main_rf_rdata(main_rf_rdata),
    .ctl_rf_en(ctl_rf_en), .ctl_rf_we(ctl_rf_we), .ctl_rf_addr(ctl_rf_addr),
    .ctl_rf_wdata(ctl_rf_wdata), .ctl_rf_rdata(ctl_rf_rdata)
  );

  // internal register files (synchronous, indexed by low address byte)
  logic [31:0] ram_main [256];
  logic [7:0]  ram_ctl  [256];

  always @(posedge clk) begin
    if (main_rf_en) begin
      if (main_rf_we) ram_main[main_rf_addr[7:0]] <= main_rf_wdata;
      else            main_rf_rdata <= ram_main[main_rf_addr[7:0]];
    end
    if (ctl_rf_en) begin
      if (ctl_rf_we) ram_ctl[ctl_rf_addr[7:0]] <= ctl_rf_wdata;
      else           ctl_rf_rdata <= ram_ctl[ctl_rf_addr[7:0]];
    end
  end

  // reference model
  logic [15:0] m_pend   [2];
  bit          m_pv     [2];
  logic [15:0] m_commit [2];
  bit          m_cv     [2];
  bit          m_rd     [2];
  bit          m_ee     [2];
  logic [31:0] m_fetch  [2];
  logic [31:0] m_main   [256];
  logic [7:0]  m_ctl    [256];
  logic [15:0] last_ptr [2];

  task automatic ref_acc(input logic [7:0] a, input bit we, input logic [31:0] wd,
                         output logic [31:0] er, output bit ee, output string tag);
    int c;
    int s;
    bit viol;
    er = '0; ee = 1'b0; tag = "R1";
    if (a[1:0] != 2'b00 || a[7:5] != 3'd0 || a[3:2] == 2'd3) return;
    c = int'(a[4]);
    s = int'(a[3:2]);
    if (s == 0) begin
      if (we) begin
        viol = m_pv[c] && (m_pend[c] != wd[15:0]);
        if (m_pv[c] && !viol) begin
          m_commit[c] = wd[15:0]; m_cv[c] = 1'b1; m_pv[c] = 1'b0;
        end else begin
          m_pv[c] = 1'b1; m_cv[c] = 1'b0;
        end
        m_pend[c] = wd[15:0];
        m_rd[c] = 1'b0;
        ee = viol && m_ee[c];
        tag = viol ? (m_ee[c] ? "R7" : "R6") : "R3";
      end else begin
        er = {16'h0, m_pend[c]};
        tag = "R3";
      end
    end else if (s == 1) begin
      if (!m_cv[c]) begin
        ee = m_ee[c];
        tag = m_ee[c] ? "R7" : "R6";
      end else if (we) begin
        if (c == 1) m_ctl[m_commit[c][7:0]] = wd[7:0];
        else        m_main[m_commit[c][7:0]] = wd;
        m_rd[c] = 1'b0;
        tag = "R5";
      end else begin
        er = m_fetch[c];
        if (!m_rd[c]) begin
          m_fetch[c] = (c == 1) ? {24'h0, m_ctl[m_commit[c][7:0]]} : m_main[m_commit[c][7:0]];
          m_rd[c] = 1'b1;
        end else begin
          m_rd[c] = 1'b0;
        end
        tag = (c == 1) ? "R9" : "R4";
      end
    end else begin
      if (we) m_ee[c] = wd[15];
      else    er = {16'h0, m_ee[c], 15'h0};
      tag = "R7";
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus(input logic [7:0] a, input bit we, input logic [31:0] wd,
                     output logic [31:0] rd, output bit er);
    int n;
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = wd;
    n = 0;
    rd = '0; er = 1'b0;
    while (1) begin
      @(negedge clk);
      n++;
      if (host_ack) begin
        rd = host_rdata; er = host_err;
        break;
      end
      if (n > 20) begin
        chk("R2 no ack", 32'd0, 32'd1);
        break;
      end
    end
    host_req = 1'b0;
  endtask

  task automatic acc(input logic [7:0] a, input bit we, input logic [31:0] wd,
                     output logic [31:0] rd);
    logic [31:0] er;
    bit ee;
    string tag;
    bit ge;
    ref_acc(a, we, wd, er, ee, tag);
    bus(a, we, wd, rd, ge);
    chk({tag, " rdata"}, rd, er);
    chk({tag, " err"}, {31'h0, ge}, {31'h0, ee});
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL R2 watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    for (int i = 0; i < 256; i++) begin
      ram_main[i] = '0; ram_ctl[i] = '0; m_main[i] = '0; m_ctl[i] = '0;
    end
    for (int c = 0; c < 2; c++) begin
      m_pend[c] = '0; m_pv[c] = 0; m_commit[c] = '0; m_cv[c] = 0;
      m_rd[c] = 0; m_ee[c] = 0; m_fetch[c] = '0; last_ptr[c] = '0;
    end
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10: reset state at the ports
    chk("R10 ack", {31'h0, host_ack}, 32'h0);
    chk("R10 err", {31'h0, host_err}, 32'h0);
    chk("R10 rf_en", {30'h0, main_rf_en, ctl_rf_en}, 32'h0);
    acc(8'h08, 0, 0, rd);  chk("R10 ctrl A", rd, 32'h0);
    acc(8'h04, 0, 0, rd);  chk("R10 data before commit", rd, 32'h0);

    // R7: error reporting on channel A
    acc(8'h08, 1, 32'hFFFF_FFFF, rd);
    acc(8'h08, 0, 0, rd);  chk("R7 ctrl readback", rd, 32'h0000_8000);
    acc(8'h04, 0, 0, rd);

    // R3 / R4 / R5: commit, write, two-read fetch
    acc(8'h00, 1, 32'h1234_0005, rd);
    acc(8'h00, 1, 32'hABCD_0005, rd);
    acc(8'h00, 0, 0, rd);  chk("R3 ptr readback", rd, 32'h0000_0005);
    acc(8'h04, 1, 32'hDEAD_BEEF, rd);
    acc(8'h04, 0, 0, rd);  chk("R4 first read old", rd, 32'h0);
    acc(8'h04, 0, 0, rd);  chk("R4 second read new", rd, 32'hDEAD_BEEF);

    // R6: mismatched pair, then recovery
    acc(8'h00, 1, 32'h7, rd);
    acc(8'h00, 1, 32'h8, rd);
    acc(8'h04, 1, 32'h5555_5555, rd);
    acc(8'h00, 1, 32'h8, rd);
    acc(8'h04, 1, 32'h0BAD_F00D, rd);

    // R8 / R9: interleave channels
    acc(8'h00, 1, 32'h9, rd);
    acc(8'h10, 1, 32'h3, rd);
    acc(8'h10, 1, 32'h3, rd);
    acc(8'h14, 1, 32'h1234_56FF, rd);
    acc(8'h00, 1, 32'h9, rd);
    acc(8'h04, 1, 32'h0000_0099, rd);
    acc(8'h14, 0, 0, rd);
    acc(8'h14, 0, 0, rd);  chk("R9 zero extend", rd, 32'h0000_00FF);
    acc(8'h04, 0, 0, rd);
    acc(8'h04, 0, 0, rd);  chk("R8 channel A intact", rd, 32'h0000_0099);
    acc(8'h18, 0, 0, rd);  chk("R8 ctrl B off", rd, 32'h0);
    acc(8'h14, 1, 32'h1, rd);

    // R1: unmapped offsets
    acc(8'h0C, 1, 32'h1, rd);
    acc(8'h21, 0, 0, rd);  chk("R1 unmapped", rd, 32'h0);

    // random mix
    for (int i = 0; i < 2500; i++) begin
      int c;
      int k;
      logic [7:0]  base;
      logic [31:0] v;
      c = int'($urandom % 2);
      k = int'($urandom % 16);
      base = (c == 1) ? 8'h10 : 8'h00;
      v = $urandom;
      if (k < 5) begin
        if (($urandom % 10) < 7) v = {v[31:16], last_ptr[c]};
        else v = {v[31:16], v[15:0] & 16'h030F};
        last_ptr[c] = v[15:0];
        acc(base, 1, v, rd);
      end else if (k < 9 || k == 15) begin
        acc(base | 8'h04, 0, 0, rd);
      end else if (k < 12) begin
        acc(base | 8'h04, 1, v, rd);
      end else if (k == 12) begin
        acc(base | 8'h08, 1, v, rd);
      end else if (k == 13) begin
        acc(base | ((($urandom % 2) == 1) ? 8'h08 : 8'h00), 0, 0, rd);
      end else begin
        acc(v[7:0] | 8'h20, v[8], v, rd);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule